// File: doc/BRIEF.md
# GPIO Bank with Masked-Write Alias

This block is a bank of general-purpose I/O ports, four ports of eight pins by default, controlled through a plain 32-bit register bus. Each port has eight 8-bit registers: pin function select, output enable, output level, synchronised input level, interrupt status, interrupt enable, interrupt mode and interrupt clear. The register type sits in address bits 6:4, so the stride is 0x10. The port index sits in bits 3:2, so the stride is 0x4. Software reaches each register at its base address, where a write replaces all eight bits.

Each register also has a second address with bit 7 set (base + 0x80). A write there carries a per-bit mask in write-data bits 15:8 and new values in bits 7:0. Only the masked bits change, so one pin can be updated without a read-modify-write sequence.

On the pin side the bank drives output levels, output enables and a per-pin function select. It samples the input pins through a two-flop synchroniser, and it raises one interrupt line per port. A pin can interrupt on a high level or on a rising edge.

Top module: `gpio_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every register returns to zero. After such an edge, pin_oe, pin_gpio, pin_out and irq are all zero.
- R2: A write to address 0x10*type + 0x4*port (bit 7 clear) replaces all 8 bits of that register. The type codes are: 0 function, 1 output enable, 2 output level, 3 input, 4 interrupt status, 5 interrupt enable, 6 interrupt mode, 7 interrupt clear. A read returns the register in rdata[7:0] with rdata[31:8] zero.
- R3: A write to the same address + 0x80 sets bit i to wdata[i] only where wdata[8+i] is 1, and leaves every other bit unchanged. A read at the +0x80 address returns the same value as the base address.
- R4: pin_gpio equals the function register bit by bit. A 1 gives the pin to GPIO, and a 0 hands it to its special function.
- R5: pin_out equals the output level register. pin_oe for a pin is 1 only when both its function bit and its output-enable bit are 1.
- R6: A read of the input register (type 3) returns pin_in as it was two clock edges earlier. Writes to it have no effect.
- R7: When the mode bit of an enabled pin is 1, its status bit is set in every cycle that the synchronised input is high. When the mode bit is 0, the status bit is set on a rising edge of the synchronised input, and it stays set after the input falls.
- R8: A write to the interrupt-clear register clears each status bit whose written value is 1. At the +0x80 address, the bit's mask must also be 1. A condition that is present in the same cycle as the clear wins, and the bit stays set. The clear register reads as zero, and direct writes to the status register have no effect.
- R9: A pin whose enable bit is 0 never sets its status bit. irq[p] is 1 exactly when port p has a status bit set whose enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; mask in 15:8 and values in 7:0 at alias addresses |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPORT*8 | Raw pin input levels |
| pin_out | output | NPORT*8 | Driven pin levels |
| pin_oe | output | NPORT*8 | Pin drive enable |
| pin_gpio | output | NPORT*8 | Function select, 1 = GPIO |
| irq | output | NPORT | Per-port interrupt request |

## Verification
A corrupted function, enable or level register shows on pin_gpio, pin_oe or pin_out on the edge right after the write, so a wrong merge of mask and value appears within one cycle. Faults in the synchroniser or the edge detector appear only through reads of the input and status registers, two to three edges after a pin changes. The stimulus therefore samples at those exact cycles. A clear that loses against a live condition, or a disabled pin that still latches status, shows up as a wrong status readback and as a wrong irq level.

// File: rtl/gpio_bank_pkg.sv
// Package: shared types and helpers for the GPIO bank.
// Assumes 8 pins per port and an 8-bit byte address with
// bit 7 = masked alias, bits 6:4 = register kind, bits 3:2 = port.
package gpio_bank_pkg;
    localparam int PINS_PER_PORT = 8;
    localparam int BUS_W         = 32;
    localparam int ADDR_W        = 8;

    typedef enum logic [2:0] {
        REG_FUNC  = 3'd0,
        REG_DIR   = 3'd1,
        REG_DRIVE = 3'd2,
        REG_LEVEL = 3'd3,
        REG_ISTAT = 3'd4,
        REG_IEN   = 3'd5,
        REG_IMODE = 3'd6,
        REG_ICLR  = 3'd7
    } gpio_reg_e;

    typedef struct packed {
        logic                     en;
        gpio_reg_e                kind;
        logic [PINS_PER_PORT-1:0] mask;
        logic [PINS_PER_PORT-1:0] val;
    } bank_wr_t;

    // Merge new values into old ones under a bit mask
    function automatic logic [PINS_PER_PORT-1:0] merge_bits(
        input logic [PINS_PER_PORT-1:0] old_v,
        input logic [PINS_PER_PORT-1:0] mask,
        input logic [PINS_PER_PORT-1:0] val);
        return (old_v & ~mask) | (val & mask);
    endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
// Address decode: splits a bus access into port, register kind and a
// masked write. Base addresses give a full-byte mask; alias addresses
// take the mask from wdata[15:8]. Assumes NPORT <= 4.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [1:0]        port_sel,
    output logic              port_ok,
    output gpio_reg_e         kind,
    output bank_wr_t          wr_req
);
    logic is_alias;

    // Field extraction and mask selection
    always_comb begin
        is_alias    = addr[7];
        kind        = gpio_reg_e'(addr[6:4]);
        port_sel    = addr[3:2];
        port_ok     = int'(addr[3:2]) < NPORT;
        wr_req.en   = wr && port_ok;
        wr_req.kind = kind;
        wr_req.val  = wdata[PINS_PER_PORT-1:0];
        wr_req.mask = is_alias ? wdata[2*PINS_PER_PORT-1:PINS_PER_PORT]
                               : {PINS_PER_PORT{1'b1}};
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Input synchroniser: two flops for metastability, then a third stage
// that remembers the previous synchronised level for rising-edge detect.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    // Shift the raw level through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl  = sync_q;
    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/gpio_port.sv
// One port of eight pins: configuration registers and interrupt status.
// Assumes wr.en is already qualified for this port. A set condition
// beats a clear in the same cycle.
module gpio_port
    import gpio_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  bank_wr_t                 wr,
    input  logic [PINS_PER_PORT-1:0] lvl,
    input  logic [PINS_PER_PORT-1:0] rise,
    output logic [PINS_PER_PORT-1:0] func_q,
    output logic [PINS_PER_PORT-1:0] dir_q,
    output logic [PINS_PER_PORT-1:0] drive_q,
    output logic [PINS_PER_PORT-1:0] ien_q,
    output logic [PINS_PER_PORT-1:0] imode_q,
    output logic [PINS_PER_PORT-1:0] istat_q,
    output logic                     irq
);
    logic [PINS_PER_PORT-1:0] clr_bits, hit_bits, istat_d;

    // Status next state: clear requested bits, then set on live conditions
    always_comb begin
        clr_bits = (wr.en && wr.kind == REG_ICLR) ? (wr.mask & wr.val) : '0;
        hit_bits = ien_q & ((imode_q & lvl) | (~imode_q & rise));
        istat_d  = (istat_q & ~clr_bits) | hit_bits;
    end

    // Configuration registers, updated by full or masked writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q  <= '0;
            dir_q   <= '0;
            drive_q <= '0;
            ien_q   <= '0;
            imode_q <= '0;
        end else if (wr.en) begin
            case (wr.kind)
                REG_FUNC:  func_q  <= merge_bits(func_q,  wr.mask, wr.val);
                REG_DIR:   dir_q   <= merge_bits(dir_q,   wr.mask, wr.val);
                REG_DRIVE: drive_q <= merge_bits(drive_q, wr.mask, wr.val);
                REG_IEN:   ien_q   <= merge_bits(ien_q,   wr.mask, wr.val);
                REG_IMODE: imode_q <= merge_bits(imode_q, wr.mask, wr.val);
                default: ;
            endcase
        end
    end

    // Interrupt status register
    always_ff @(posedge clk) begin
        if (!rst_n) istat_q <= '0;
        else        istat_q <= istat_d;
    end

    assign irq = |(istat_q & ien_q);
endmodule

// File: rtl/gpio_bank.sv
// GPIO bank top: address decode, per-port register slices, input
// synchroniser and combinational read mux. Reads are side-effect free.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPORT = 4,
    localparam int NPIN = NPORT * PINS_PER_PORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_gpio,
    output logic [NPORT-1:0]  irq
);
    logic [1:0] port_sel;
    logic       port_ok;
    gpio_reg_e  kind;
    bank_wr_t   wr_req;

    logic [NPORT-1:0][PINS_PER_PORT-1:0] lvl, rise;
    logic [NPORT-1:0][PINS_PER_PORT-1:0] func_q, dir_q, drive_q;
    logic [NPORT-1:0][PINS_PER_PORT-1:0] ien_q, imode_q, istat_q;

    gpio_addr_decode #(.NPORT(NPORT)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .port_sel (port_sel),
        .port_ok  (port_ok),
        .kind     (kind),
        .wr_req   (wr_req)
    );

    gpio_in_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_in),
        .lvl   (lvl),
        .rise  (rise)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        bank_wr_t port_wr;

        // Qualify the shared write with this port's select
        always_comb begin
            port_wr    = wr_req;
            port_wr.en = wr_req.en && (int'(port_sel) == p);
        end

        gpio_port u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (port_wr),
            .lvl     (lvl[p]),
            .rise    (rise[p]),
            .func_q  (func_q[p]),
            .dir_q   (dir_q[p]),
            .drive_q (drive_q[p]),
            .ien_q   (ien_q[p]),
            .imode_q (imode_q[p]),
            .istat_q (istat_q[p]),
            .irq     (irq[p])
        );
    end

    assign pin_out  = drive_q;
    assign pin_gpio = func_q;
    assign pin_oe   = func_q & dir_q;

    // Read mux: selected register in the low byte, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        if (port_ok) begin
            case (kind)
                REG_FUNC:  bus_rdata[PINS_PER_PORT-1:0] = func_q[port_sel];
                REG_DIR:   bus_rdata[PINS_PER_PORT-1:0] = dir_q[port_sel];
                REG_DRIVE: bus_rdata[PINS_PER_PORT-1:0] = drive_q[port_sel];
                REG_LEVEL: bus_rdata[PINS_PER_PORT-1:0] = lvl[port_sel];
                REG_ISTAT: bus_rdata[PINS_PER_PORT-1:0] = istat_q[port_sel];
                REG_IEN:   bus_rdata[PINS_PER_PORT-1:0] = ien_q[port_sel];
                REG_IMODE: bus_rdata[PINS_PER_PORT-1:0] = imode_q[port_sel];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bank_checker.sv
// Checker for gpio_bank: port-level temporal properties, bound to the top.
module gpio_bank_checker #(
    parameter int NPORT = 4,
    localparam int NPIN = NPORT * 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic             bus_wr,
    input logic [31:0]      bus_wdata,
    input logic [NPIN-1:0]  pin_out,
    input logic [NPIN-1:0]  pin_oe,
    input logic [NPIN-1:0]  pin_gpio,
    input logic [NPORT-1:0] irq
);
    logic [1:0] wport;
    logic       drive_wr;
    logic [7:0] cur_byte, exp_byte;

    // Expected output byte after a write to the output-level register
    always_comb begin
        wport    = bus_addr[3:2];
        drive_wr = bus_wr && bus_addr[6:4] == 3'd2 && int'(wport) < NPORT;
        cur_byte = (int'(wport) < NPORT) ? pin_out[int'(wport)*8 +: 8] : 8'h00;
        if (bus_addr[7])
            exp_byte = (cur_byte & ~bus_wdata[15:8]) | (bus_wdata[7:0] & bus_wdata[15:8]);
        else
            exp_byte = bus_wdata[7:0];
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_gpio == '0 && pin_out == '0 && irq == '0));

    a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        drive_wr && !bus_addr[7] |=> pin_out[int'($past(wport))*8 +: 8] == $past(bus_wdata[7:0]));

    a_r3_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        drive_wr && bus_addr[7] |=> pin_out[int'($past(wport))*8 +: 8] == $past(exp_byte));

    a_r4_func_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[6:4] == 3'd0) |=> $stable(pin_gpio));

    a_r5_oe_needs_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~pin_gpio) == '0);
endmodule

bind gpio_bank gpio_bank_checker #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_gpio  (pin_gpio),
    .irq       (irq)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    localparam int NPORT = 4;
    localparam int NPIN  = NPORT * 8;
    localparam int NVEC  = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out, pin_oe, pin_gpio;
    logic [NPORT-1:0] irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    gpio_bank #(.NPORT(NPORT)) i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_gpio(pin_gpio), .irq(irq)
    );

    // Vector: {req[3:0], is_write, addr[7:0], wdata[15:0], expect[7:0]}
    localparam logic [36:0] VEC [NVEC] = '{
        {4'd2, 1'b1, 8'h20, 16'h00A5, 8'h00},  // R2 full write drive p0
        {4'd2, 1'b0, 8'h20, 16'h0000, 8'hA5},  // R2 read back
        {4'd3, 1'b1, 8'hA0, 16'h0F0A, 8'h00},  // R3 low nibble only
        {4'd3, 1'b0, 8'h20, 16'h0000, 8'hAA},  // R3 base read
        {4'd3, 1'b0, 8'hA0, 16'h0000, 8'hAA},  // R3 alias read
        {4'd2, 1'b1, 8'h04, 16'h00FF, 8'h00},  // R2 function p1
        {4'd3, 1'b1, 8'h84, 16'h8101, 8'h00},  // R3 mask bits 7 and 0
        {4'd3, 1'b0, 8'h04, 16'h0000, 8'h7F},
        {4'd2, 1'b1, 8'h1C, 16'h003C, 8'h00},  // R2 direction p3
        {4'd3, 1'b1, 8'h9C, 16'h00FF, 8'h00},  // R3 empty mask
        {4'd3, 1'b0, 8'h1C, 16'h0000, 8'h3C},
        {4'd2, 1'b1, 8'h58, 16'h0055, 8'h00},  // R2 enable p2
        {4'd2, 1'b0, 8'h58, 16'h0000, 8'h55},
        {4'd8, 1'b0, 8'h70, 16'h0000, 8'h00}   // R8 clear reads zero
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp,
                         input string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        check(1, {pin_oe, pin_gpio}, '0, "pins after reset");
        check(1, {28'd0, irq}, '0, "irq after reset");
        bus_read(8'h24, rd); check(1, rd, 32'h0, "drive p1 after reset");

        // Table walk: R2 and R3
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][32]) bus_write(VEC[i][31:24], {16'h0, VEC[i][23:8]});
            else begin
                bus_read(VEC[i][31:24], rd);
                check(int'(VEC[i][36:33]), rd, {24'h0, VEC[i][7:0]}, $sformatf("vector %0d", i));
            end
        end

        // R4 / R5: pin-side outputs
        check(4, {24'h0, pin_gpio[15:8]}, 32'h7F, "function select p1");
        check(5, {24'h0, pin_out[7:0]}, 32'hAA, "drive level p0");
        check(5, {24'h0, pin_oe[31:24]}, 32'h0, "oe gated by function p3");
        bus_write(8'h14, 32'h00F0);
        check(5, {24'h0, pin_oe[15:8]}, 32'h70, "oe p1");
        bus_write(8'h84, 32'h8080);
        check(4, {24'h0, pin_gpio[15:8]}, 32'hFF, "function alias p1");
        check(5, {24'h0, pin_oe[15:8]}, 32'hF0, "oe after function set");

        // R6: two-edge input latency, writes ignored
        @(negedge clk);
        pin_in[7:0] = 8'h5A; bus_addr = 8'h30;
        @(negedge clk); #1 check(6, bus_rdata, 32'h00, "input after one edge");
        @(negedge clk); #1 check(6, bus_rdata, 32'h5A, "input after two edges");
        bus_write(8'h30, 32'h00FF);
        bus_read(8'h30, rd); check(6, rd, 32'h5A, "input write ignored");

        // R9: disabled pins did not latch; R8: status writes ignored
        bus_read(8'h40, rd); check(9, rd, 32'h0, "no status while disabled");
        bus_write(8'h40, 32'h00FF);
        bus_read(8'h40, rd); check(8, rd, 32'h0, "status write ignored");

        // R7 edge mode on p0 bit0
        bus_write(8'h50, 32'h0001);
        pin_in[0] = 1'b1; idle(4);
        bus_read(8'h40, rd); check(7, rd, 32'h01, "edge sets status");
        check(9, {31'h0, irq[0]}, 32'h1, "irq p0 raised");
        pin_in[0] = 1'b0; idle(4);
        bus_read(8'h40, rd); check(7, rd, 32'h01, "edge status held after fall");
        bus_write(8'hF0, 32'h00FF);
        bus_read(8'h40, rd); check(8, rd, 32'h01, "alias clear with empty mask");
        bus_write(8'h70, 32'h0001);
        bus_read(8'h40, rd); check(8, rd, 32'h00, "clear edge status");
        check(9, {31'h0, irq[0]}, 32'h0, "irq p0 dropped");

        // R7 level mode on p0 bit1 (pin high)
        bus_write(8'h60, 32'h0002);
        bus_write(8'h50, 32'h0003);
        idle(1);
        bus_read(8'h40, rd); check(7, rd, 32'h02, "level sets status");
        bus_write(8'hF0, 32'h0202);
        bus_read(8'h40, rd); check(8, rd, 32'h02, "set wins over clear");
        pin_in[1] = 1'b0; idle(4);
        bus_write(8'hF0, 32'h0202);
        bus_read(8'h40, rd); check(8, rd, 32'h00, "alias clear after level low");

        // R9: toggle disabled bit3
        pin_in[3] = 1'b0; idle(4);
        pin_in[3] = 1'b1; idle(4);
        bus_read(8'h40, rd); check(9, rd, 32'h00, "disabled edge ignored");
        check(9, {28'h0, irq}, 32'h0, "no irq anywhere");

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(1, {pin_out, pin_gpio}, '0, "pins after second reset");
        bus_read(8'h60, rd); check(1, rd, 32'h0, "mode after second reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule